// File: doc/BRIEF.md
# Shared Multi-Line Receive Silo

This block gathers characters from up to eight serial line receivers into a single first-in first-out store of 64 entries that all lines share. Each receiver presents a one-cycle strobe together with its character, a parity-error flag, a framing-error flag and a break indication. The block tags every accepted character with the number of the line it came from and with its error flags, and writes it into the silo. When several lines strobe in the same cycle, their characters go in by ascending line number. A line's characters are accepted only if the global scan enable is on and that line's receiver has been enabled.

The host drains the silo through a receive-buffer port. The word at the head of the silo is always visible on `rd_word`. A one-cycle `rd_en` pulse removes that entry. The host keeps reading until the valid bit of the word is clear. A control register holds a scan enable, a receive-interrupt enable and an alarm enable. With the alarm off, the interrupt is raised while anything is queued. With the alarm on, it is held back until 16 or more characters are waiting, which cuts the interrupt rate on busy lines.

When the silo is full, new characters are lost. The next character that does get stored carries an overrun flag, so the host can tell that data went missing before it.

Top module: `rx_silo`

## Requirements
- R1: After reset, the silo is empty, `rd_word` is zero, `irq` is low, the control register is zero and every line's receiver is disabled.
- R2: Layout of a non-empty read word:
  - bits 7:0 hold the character;
  - bits 11:8 hold the source line number;
  - bit 12 is parity error, bit 13 is framing error, bit 14 is overrun;
  - bit 15 is the valid bit and is set.
- R3: Entries are read back in the order they were stored. The host drains the silo by reading until bit 15 of `rd_word` is clear.
- R4: Characters strobed on several lines in the same cycle are stored in ascending order of line number.
- R5: While the scan enable (control bit 0) is clear, no character is stored.
- R6: A strobe on a line is ignored unless that line's receiver enable was last written as 1 through the line-parameter port (`lp_wr`, `lp_line`, `lp_rx_en`).
- R7: A strobe with the break indication set is stored with character zero and the framing-error bit set. Its parity flag is kept as received.
- R8: The silo holds 64 entries. A character that arrives while it is full is dropped, and the next entry that is stored has the overrun bit set. Later entries have it clear.
- R9: When the silo is empty, `rd_word` reads zero, and a read has no effect on the entries that follow.
- R10: With the interrupt enable (control bit 1) set and the alarm enable (control bit 2) clear, `irq` is high exactly while the silo is non-empty.
- R11: With the interrupt enable and the alarm enable both set, `irq` is high only while 16 or more entries are queued.
- R12: With the interrupt enable clear, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ln_stb | input | 8 | Per-line character strobe, one cycle per character |
| ln_data | input | 64 | Per-line character; line i uses bits 8i+7:8i |
| ln_perr | input | 8 | Per-line parity-error flag |
| ln_ferr | input | 8 | Per-line framing-error flag |
| ln_brk | input | 8 | Per-line break indication |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control value: bit 0 scan enable, bit 1 interrupt enable, bit 2 alarm enable |
| lp_wr | input | 1 | Line-parameter write strobe |
| lp_line | input | 3 | Line selected by the line-parameter write |
| lp_rx_en | input | 1 | Receiver enable written to the selected line |
| rd_en | input | 1 | Removes the head entry of the silo |
| rd_word | output | 16 | Head entry of the silo (zero when empty) |
| irq | output | 1 | Receive interrupt request |

## Verification
Strobes and register writes take effect at the first rising edge that sees them. The stored entry, the new `rd_word` and the new `irq` level can all be seen straight after that edge. A read pulse likewise moves the head at its edge. Every input is driven on a falling edge and held for one full cycle, and every result is sampled on the next falling edge, half a cycle after the edge that produced it. Corner cases are checked as a sequence of single-cycle steps:
- the 15th and 16th entries in alarm mode;
- the 64th entry and the dropped ones that follow it;
- the first entry stored after the drop.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
    localparam int CHAR_W     = 8;
    localparam int LINE_FLD_W = 4;
    localparam int WORD_W     = 16;

    // Layout of one silo entry; the packed order is the host-visible word order.
    typedef struct packed {
        logic                  ovr;
        logic                  ferr;
        logic                  perr;
        logic [LINE_FLD_W-1:0] line;
        logic [CHAR_W-1:0]     ch;
    } entry_t;

    typedef struct packed {
        logic alarm_en;
        logic rxie;
        logic scan_en;
    } ctl_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic valid, input entry_t e);
        return {valid, e};
    endfunction
endpackage

// File: rtl/rx_silo_accept.sv
module rx_silo_accept #(
    parameter int NUM_LINES = 8,
    parameter int DEPTH     = 64,
    parameter int CW        = 7,
    parameter int RW        = 4
) (
    input  logic [NUM_LINES-1:0]         strobe,
    input  logic [NUM_LINES-1:0]         rx_en,
    input  logic                         scan_en,
    input  logic [CW-1:0]                count,
    output logic [NUM_LINES-1:0]         wr_ok,
    output logic [NUM_LINES-1:0][RW-1:0] rank,
    output logic [RW-1:0]                n_store,
    output logic                         drop_any
);
    // Walk the lines in ascending order; each accepted line takes the next free slot.
    always_comb begin
        logic [RW-1:0] run;
        logic          acc;
        run      = '0;
        drop_any = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            acc      = strobe[i] & rx_en[i] & scan_en;
            rank[i]  = run;
            wr_ok[i] = acc && ((int'(count) + int'(run)) < DEPTH);
            drop_any = drop_any | (acc & ~wr_ok[i]);
            run      = run + RW'(wr_ok[i]);
        end
        n_store = run;
    end
endmodule

// File: rtl/rx_silo_store.sv
module rx_silo_store
    import rx_silo_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int DEPTH     = 64,
    parameter int AW        = 6,
    parameter int CW        = 7,
    parameter int RW        = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_LINES-1:0]         wr_ok,
    input  logic [NUM_LINES-1:0][RW-1:0] rank,
    input  logic [RW-1:0]                n_store,
    input  logic                         drop_any,
    input  entry_t [NUM_LINES-1:0]       ent,
    input  logic                         pop_req,
    output entry_t                       head,
    output logic [CW-1:0]                count,
    output logic [AW-1:0]                rptr,
    output logic                         ovr_pend
);
    entry_t        mem [DEPTH];
    logic [AW-1:0] wptr;
    logic          pop;

    assign pop  = pop_req && (count != '0);
    assign head = mem[rptr];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (wr_ok[i]) begin
                mem[wptr + AW'(rank[i])] <= ent[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            ovr_pend <= 1'b0;
        end else begin
            wptr  <= wptr + AW'(n_store);
            rptr  <= rptr + AW'(pop);
            count <= count + CW'(n_store) - CW'(pop);
            if (drop_any) begin
                ovr_pend <= 1'b1;
            end else if (n_store != '0) begin
                ovr_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rx_silo.sv
module rx_silo
    import rx_silo_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int DEPTH       = 64,
    parameter int ALARM_LEVEL = 16,
    localparam int LW         = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LINES-1:0]        ln_stb,
    input  logic [NUM_LINES*CHAR_W-1:0] ln_data,
    input  logic [NUM_LINES-1:0]        ln_perr,
    input  logic [NUM_LINES-1:0]        ln_ferr,
    input  logic [NUM_LINES-1:0]        ln_brk,
    input  logic                        ctl_wr,
    input  logic [2:0]                  ctl_wdata,
    input  logic                        lp_wr,
    input  logic [LW-1:0]               lp_line,
    input  logic                        lp_rx_en,
    input  logic                        rd_en,
    output logic [WORD_W-1:0]           rd_word,
    output logic                        irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int RW = $clog2(NUM_LINES + 1);

    ctl_t                         ctl_q;
    logic [NUM_LINES-1:0]         rx_en_q;
    logic [NUM_LINES-1:0]         wr_ok;
    logic [NUM_LINES-1:0][RW-1:0] rank;
    logic [RW-1:0]                n_store;
    logic                         drop_any;
    entry_t [NUM_LINES-1:0]       ent;
    entry_t                       head;
    logic [CW-1:0]                count;
    logic [AW-1:0]                rptr;
    logic                         ovr_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            rx_en_q <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_q <= ctl_t'(ctl_wdata);
            end
            if (lp_wr) begin
                rx_en_q[lp_line] <= lp_rx_en;
            end
        end
    end

    // Per-line entry formation: break forces a zero character with framing error.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_comb begin
            ent[g].ch   = ln_brk[g] ? '0 : ln_data[g*CHAR_W +: CHAR_W];
            ent[g].ferr = ln_ferr[g] | ln_brk[g];
            ent[g].perr = ln_perr[g];
            ent[g].line = LINE_FLD_W'(g);
            ent[g].ovr  = ovr_pend && (rank[g] == '0);
        end
    end

    rx_silo_accept #(
        .NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .CW(CW), .RW(RW)
    ) u_accept (
        .strobe(ln_stb), .rx_en(rx_en_q), .scan_en(ctl_q.scan_en), .count(count),
        .wr_ok(wr_ok), .rank(rank), .n_store(n_store), .drop_any(drop_any)
    );

    rx_silo_store #(
        .NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .AW(AW), .CW(CW), .RW(RW)
    ) u_store (
        .clk(clk), .rst(rst), .wr_ok(wr_ok), .rank(rank), .n_store(n_store),
        .drop_any(drop_any), .ent(ent), .pop_req(rd_en), .head(head),
        .count(count), .rptr(rptr), .ovr_pend(ovr_pend)
    );

    assign rd_word = (count != '0) ? pack_word(1'b1, head) : '0;

    always_comb begin
        if (!ctl_q.rxie) begin
            irq = 1'b0;
        end else if (ctl_q.alarm_en) begin
            irq = (int'(count) >= ALARM_LEVEL);
        end else begin
            irq = (count != '0);
        end
    end
endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
    parameter int DEPTH = 64,
    parameter int ALARM = 16,
    parameter int AW    = 6,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic [15:0]   rd_word,
    input logic          irq,
    input logic          scan_en,
    input logic          rxie,
    input logic          alarm_en,
    input logic [CW-1:0] count,
    input logic [AW-1:0] rptr
);
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !rxie |-> !irq);

    // R11
    alarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_en && (int'(count) < ALARM)) |-> !irq);

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && rd_en) |=> $stable(rptr));

    // R5
    scan_off_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> (count <= $past(count)));

    // R2
    invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_word[15] |-> (rd_word == 16'h0000));
endmodule

bind rx_silo rx_silo_chk #(
    .DEPTH(DEPTH), .ALARM(ALARM_LEVEL), .AW(AW), .CW(CW)
) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_word(rd_word), .irq(irq),
    .scan_en(ctl_q.scan_en), .rxie(ctl_q.rxie), .alarm_en(ctl_q.alarm_en),
    .count(count), .rptr(rptr)
);

// File: tb/rx_silo_test.sv
`timescale 1ns/1ps
module rx_silo_test;
    localparam int NL = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NL-1:0] ln_stb, ln_perr, ln_ferr, ln_brk;
    logic [NL*8-1:0] ln_data;
    logic          ctl_wr, lp_wr, lp_rx_en, rd_en;
    logic [2:0]    ctl_wdata, lp_line;
    logic [15:0]   rd_word;
    logic          irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rx_silo uut (
        .clk(clk), .rst(rst), .ln_stb(ln_stb), .ln_data(ln_data),
        .ln_perr(ln_perr), .ln_ferr(ln_ferr), .ln_brk(ln_brk),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .lp_wr(lp_wr),
        .lp_line(lp_line), .lp_rx_en(lp_rx_en), .rd_en(rd_en),
        .rd_word(rd_word), .irq(irq)
    );

    // Stimulus bits: 7:0 char, 10:8 line, 12 perr, 13 ferr, 14 brk. Upper half: expected word.
    localparam logic [31:0] VEC [8] = '{
        {16'h8041, 16'h0041}, {16'h935A, 16'h135A},
        {16'hA7FF, 16'h27FF}, {16'hA500, 16'h4533},
        {16'h8200, 16'h0200}, {16'hB6C3, 16'h36C3},
        {16'h817E, 16'h017E}, {16'hB400, 16'h5499}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input int line, input logic [7:0] d,
                        input logic pe, input logic fe, input logic bk);
        @(negedge clk);
        ln_stb[line] = 1'b1;
        ln_data[line*8 +: 8] = d;
        ln_perr[line] = pe;
        ln_ferr[line] = fe;
        ln_brk[line] = bk;
        @(negedge clk);
        ln_stb = '0; ln_perr = '0; ln_ferr = '0; ln_brk = '0;
    endtask

    task automatic pop_chk(input string req, input logic [15:0] exp);
        chk(req, rd_word, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_ctl(input logic [2:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic set_line(input int line, input logic en);
        @(negedge clk);
        lp_wr = 1'b1; lp_line = 3'(line); lp_rx_en = en;
        @(negedge clk);
        lp_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ln_stb = '0; ln_perr = '0; ln_ferr = '0; ln_brk = '0; ln_data = '0;
        ctl_wr = 1'b0; ctl_wdata = '0; lp_wr = 1'b0; lp_line = '0;
        lp_rx_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_word", rd_word, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0000);

        // R1/R6: receivers are disabled after reset even with scan on
        set_ctl(3'b011);
        push(0, 8'h55, 1'b0, 1'b0, 1'b0);
        chk("R1 R6 line disabled at reset", rd_word, 16'h0000);

        for (int i = 0; i < NL; i++) set_line(i, 1'b1);

        // R2/R3/R7: table walk, store all then drain in order
        for (int k = 0; k < 8; k++) begin
            push(int'(VEC[k][10:8]), VEC[k][7:0], VEC[k][12], VEC[k][13], VEC[k][14]);
        end
        chk("R10 irq non-empty", {15'b0, irq}, 16'h0001);
        for (int k = 0; k < 8; k++) pop_chk("R2 R3 R7 table word", VEC[k][31:16]);
        chk("R3 drained valid clear", rd_word, 16'h0000);
        chk("R10 irq empty", {15'b0, irq}, 16'h0000);

        // R4: simultaneous strobes stored by ascending line
        @(negedge clk);
        ln_stb = 8'b0100_1010;
        ln_data = '0;
        ln_data[6*8 +: 8] = 8'h66; ln_data[1*8 +: 8] = 8'h11; ln_data[3*8 +: 8] = 8'h33;
        @(negedge clk);
        ln_stb = '0;
        pop_chk("R4 first", 16'h8111);
        pop_chk("R4 second", 16'h8333);
        pop_chk("R4 third", 16'h8666);

        // R12: interrupt enable off
        set_ctl(3'b001);
        push(2, 8'h20, 1'b0, 1'b0, 1'b0);
        chk("R12 irq masked", {15'b0, irq}, 16'h0000);
        pop_chk("R12 entry", 16'h8220);

        // R5: scan off captures nothing
        set_ctl(3'b010);
        push(4, 8'h44, 1'b0, 1'b0, 1'b0);
        chk("R5 scan off", rd_word, 16'h0000);
        set_ctl(3'b011);

        // R6: one line disabled
        set_line(2, 1'b0);
        push(2, 8'h22, 1'b0, 1'b0, 1'b0);
        chk("R6 disabled line", rd_word, 16'h0000);
        push(3, 8'h23, 1'b0, 1'b0, 1'b0);
        pop_chk("R6 enabled line", 16'h8323);
        set_line(2, 1'b1);

        // R9: read while empty
        pop_chk("R9 empty word", 16'h0000);
        push(5, 8'h5E, 1'b0, 1'b0, 1'b0);
        push(6, 8'h6E, 1'b0, 1'b0, 1'b0);
        pop_chk("R9 after empty read", 16'h855E);
        pop_chk("R9 second after empty read", 16'h866E);

        // R11: alarm mode threshold
        set_ctl(3'b111);
        for (int k = 0; k < 15; k++) push(1, 8'(k), 1'b0, 1'b0, 1'b0);
        chk("R11 15 queued", {15'b0, irq}, 16'h0000);
        push(1, 8'd15, 1'b0, 1'b0, 1'b0);
        chk("R11 16 queued", {15'b0, irq}, 16'h0001);
        pop_chk("R11 head", 16'h8100);
        chk("R11 back to 15", {15'b0, irq}, 16'h0000);
        for (int k = 1; k < 16; k++) pop_chk("R11 drain", 16'h8100 | 16'(k));

        // R8: fill, drop, overrun flag on next stored entry
        set_ctl(3'b011);
        for (int k = 0; k < 64; k++) push(0, 8'(k), 1'b0, 1'b0, 1'b0);
        push(0, 8'hEE, 1'b0, 1'b0, 1'b0);
        push(7, 8'hEF, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 64; k++) pop_chk("R8 full drain", 16'h8000 | 16'(k));
        chk("R8 dropped not stored", rd_word, 16'h0000);
        push(0, 8'h11, 1'b0, 1'b0, 1'b0);
        push(0, 8'h12, 1'b0, 1'b0, 1'b0);
        pop_chk("R8 overrun flagged", 16'hC011);
        pop_chk("R8 overrun cleared", 16'h8012);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule